// File: doc/BRIEF.md
# Pulse-Count Status Transmitter

This block returns a result code to an external microcontroller once a command has been handled. It drives two lines only. One is a framing line and the other is a pulse line. The status is encoded as a number of pulses, and zero pulses means the command was accepted. A one-cycle start strobe latches a 3-bit status code. The block then shows a busy pattern: the framing line is low and the pulse line is high. After that it raises the framing line and emits as many pulses as the code says. It then drops the framing line and flags completion with a one-cycle done strobe.

The code values are as follows:

| Code | Meaning |
|------|---------|
| 0 | accepted |
| 1 | supply too low |
| 2 | storage full |
| 3 | no free message slot |
| 4 | pointer invalid |
| 5 | command not recognised |
| 6 | unspecified fault |

All phase lengths are parameters counted in clock cycles. With the default 768 kHz clock, a 5 ms gap is 3840 cycles. A pulse line running at 100 Hz with a 50 % duty cycle also gives a 3840-cycle half period.

Top module: `status_pulse_tx`

## Requirements
- R1: After reset, and whenever the block is idle, `frame_o`, `pulse_o` and `done_o` are all low.
- R2: If `start_i` is high on a clock edge while the block is idle, then for the next `BUSY_CYC` cycles `frame_o`=0 and `pulse_o`=1 (busy pattern).
- R3: After the busy pattern, `frame_o` goes high and stays high with `pulse_o` low for `GAP_CYC` cycles before the first pulse.
- R4: The number of pulses inside the frame equals the latched code (0 to 6). A code of 0 gives a frame with no pulse inside it.
- R5: Each pulse is high for `HALF_CYC` cycles and is followed by `HALF_CYC` low cycles.
- R6: After the low half of the last pulse, `frame_o` stays high for `GAP_CYC` more cycles and then falls. With code 0 the frame is high for exactly `2*GAP_CYC` cycles.
- R7: Code 7 is not defined and is sent as 6 pulses.
- R8: While a report is in progress, `start_i` and changes on `code_i` have no effect on the waveform being sent.
- R9: `done_o` is high for exactly one cycle: the first cycle in which `frame_o` is low after a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| code_i | input | 3 | Status code latched at start |
| frame_o | output | 1 | Framing line |
| pulse_o | output | 1 | Pulse line (high with frame low = busy) |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The bench builds the block with `BUSY_CYC`=3, `GAP_CYC`=4 and `HALF_CYC`=2. These short phases make every phase boundary, every code from 0 to 7 and back-to-back reports cheap to reach, and each report is compared cycle by cycle against a waveform computed in the bench. Random start strobes and code changes are injected during reports to show that they are ignored. The counter widths still follow the parameters, so the same logic scales to the 3840-cycle defaults.

// File: rtl/status_pulse_pkg.sv
// Shared types and constants for the pulse-count status transmitter.
package status_pulse_pkg;
    localparam int CODE_W   = 3;
    localparam int MAX_CODE = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BUSY,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TAIL
    } tx_state_e;
endpackage

// File: rtl/phase_timer.sv
// Down-counting phase timer.
// Assumes: load has priority; zero_o is high when the count has run out.
module phase_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    // Load a new phase length or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (load_i)     cnt_q <= load_val_i;
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

    // The count only falls by one unless a load takes place.
    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load_i) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pulse_budget.sv
// Holds the number of pulses still to send.
// Assumes: codes above MAX_CODE are clamped to MAX_CODE when loaded.
module pulse_budget
    import status_pulse_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              dec_i,
    output logic              empty_o
);
    logic [CODE_W-1:0] left_q;
    logic [CODE_W-1:0] clamped;

    // Map an undefined code onto the highest defined one.
    always_comb begin
        clamped = (code_i > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code_i;
    end

    // Load the pulse budget at start, and spend one unit per pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)                    left_q <= '0;
        else if (load_i)               left_q <= clamped;
        else if (dec_i && !empty_o)    left_q <= left_q - 1'b1;
    end

    assign empty_o = (left_q == '0);

    // The budget never holds more than the largest defined code.
    p_budget_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        left_q <= CODE_W'(MAX_CODE));
    // The budget never grows except on a load.
    p_budget_no_grow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load_i) |-> (left_q <= $past(left_q)));
endmodule

// File: rtl/status_pulse_tx.sv
// Pulse-count status transmitter.
// It shows a busy pattern, then a framed burst of N pulses (N = status
// code, 7 clamped to 6), then a done strobe.
// Assumes: every phase length parameter is at least 1 cycle.
module status_pulse_tx
    import status_pulse_pkg::*;
#(
    parameter int BUSY_CYC = 3840,
    parameter int GAP_CYC  = 3840,
    parameter int HALF_CYC = 3840
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              frame_o,
    output logic              pulse_o,
    output logic              done_o
);
    localparam int MAX_A   = (BUSY_CYC > GAP_CYC) ? BUSY_CYC : GAP_CYC;
    localparam int MAX_LEN = (MAX_A > HALF_CYC) ? MAX_A : HALF_CYC;
    localparam int TW      = $clog2(MAX_LEN + 1);

    tx_state_e       state_q, state_d;
    logic            tmr_load, tmr_zero;
    logic [TW-1:0]   tmr_val;
    logic            bud_load, bud_dec, bud_empty;
    logic            done_q;

    phase_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load_i(tmr_load),
        .load_val_i(tmr_val), .zero_o(tmr_zero)
    );

    pulse_budget u_budget (
        .clk(clk), .rst_n(rst_n), .load_i(bud_load), .code_i(code_i),
        .dec_i(bud_dec), .empty_o(bud_empty)
    );

    // Next-state logic, phase-timer reloads and budget updates.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        bud_load = 1'b0;
        bud_dec  = 1'b0;
        unique case (state_q)
            ST_IDLE: if (start_i) begin
                state_d = ST_BUSY; tmr_load = 1'b1;
                tmr_val = TW'(BUSY_CYC - 1); bud_load = 1'b1;
            end
            ST_BUSY: if (tmr_zero) begin
                state_d = ST_LEAD; tmr_load = 1'b1; tmr_val = TW'(GAP_CYC - 1);
            end
            ST_LEAD, ST_LOW: if (tmr_zero) begin
                tmr_load = 1'b1;
                if (bud_empty) begin
                    state_d = ST_TAIL; tmr_val = TW'(GAP_CYC - 1);
                end else begin
                    state_d = ST_HIGH; tmr_val = TW'(HALF_CYC - 1);
                end
            end
            ST_HIGH: if (tmr_zero) begin
                state_d = ST_LOW; tmr_load = 1'b1;
                tmr_val = TW'(HALF_CYC - 1); bud_dec = 1'b1;
            end
            ST_TAIL: if (tmr_zero) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and the done strobe, which is high in the first idle cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_TAIL) && tmr_zero;
        end
    end

    assign frame_o = (state_q == ST_LEAD) || (state_q == ST_HIGH) ||
                     (state_q == ST_LOW)  || (state_q == ST_TAIL);
    assign pulse_o = (state_q == ST_BUSY) || (state_q == ST_HIGH);
    assign done_o  = done_q;

    // A report can only begin from idle, so a start during a report is ignored.
    p_start_from_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && $past(state_q) != ST_BUSY) |-> $past(state_q) == ST_IDLE);
    // The frame rises only directly after the busy pattern.
    p_busy_before_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_o) |-> ($past(pulse_o) && !$past(frame_o)));
    // Done follows the fall of the frame.
    p_done_after_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(frame_o) && !frame_o && !pulse_o));
    // Done lasts exactly one cycle.
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // The frame does not fall while a pulse is high.
    p_no_cut_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_o) |-> !$past(pulse_o));
endmodule

// File: tb/test_status_pulse_tx.sv
// Bench for status_pulse_tx: directed codes plus seeded random reports,
// with random start and code noise injected during each report.
module test_status_pulse_tx;
    localparam int CLK_PERIOD = 10;
    localparam int BUSY = 3;
    localparam int GAP  = 4;
    localparam int HALF = 2;
    localparam int WATCHDOG = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [2:0] code_i = 3'd0;
    logic       frame_o, pulse_o, done_o;
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         finished = 0;

    status_pulse_tx #(.BUSY_CYC(BUSY), .GAP_CYC(GAP), .HALF_CYC(HALF)) i_status_pulse_tx (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .code_i(code_i),
        .frame_o(frame_o), .pulse_o(pulse_o), .done_o(done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected pulse count for a code (R4, R7).
    function automatic int exp_count(input int code);
        return (code > 6) ? 6 : code;
    endfunction

    // Expected report length in cycles, including the done cycle.
    function automatic int exp_len(input int n);
        return BUSY + GAP + 2*HALF*n + GAP + 1;
    endfunction

    // Expected {frame, pulse, done} at cycle j of a report carrying n pulses.
    function automatic logic [2:0] exp_out(input int j, input int n);
        int k;
        if (j < BUSY) return 3'b010;
        if (j < BUSY + GAP) return 3'b100;
        k = j - BUSY - GAP;
        if (k < 2*HALF*n) return ((k % (2*HALF)) < HALF) ? 3'b110 : 3'b100;
        if (k < 2*HALF*n + GAP) return 3'b100;
        return 3'b001;
    endfunction

    // Requirement tag for the phase that cycle j belongs to.
    function automatic string phase_tag(input int j, input int n);
        int k;
        if (j < BUSY) return "R2";
        if (j < BUSY + GAP) return "R3";
        k = j - BUSY - GAP;
        if (k < 2*HALF*n) return "R5";
        if (k < 2*HALF*n + GAP) return "R6";
        return "R9";
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Send one report with a given code; noisy selects R8 noise injection.
    task automatic run_report(input int code, input bit noisy);
        int n, len, rises;
        logic prev_p;
        n = exp_count(code);
        len = exp_len(n);
        rises = 0;
        prev_p = 1'b1;
        @(negedge clk);
        start_i = 1'b1;
        code_i = 3'(code);
        for (int j = 0; j < len; j++) begin
            @(negedge clk);
            if (noisy && j < len - 1) begin
                start_i = 1'($urandom_range(0, 1));
                code_i = 3'($urandom_range(0, 7));
            end else begin
                start_i = 1'b0;
            end
            check(noisy ? {phase_tag(j, n), "/R8"} : phase_tag(j, n),
                  {frame_o, pulse_o, done_o}, exp_out(j, n));
            if (j >= BUSY && pulse_o && !prev_p) rises++;
            prev_p = pulse_o;
        end
        check(code > 6 ? "R7 pulse count" : "R4 pulse count", rises, n);
        @(negedge clk);
        check("R1 idle after report", {frame_o, pulse_o, done_o}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state", {frame_o, pulse_o, done_o}, 0);
        rst_n = 1'b1;
        // With start held low, an idle block stays quiet.
        code_i = 3'd5;
        repeat (4) @(negedge clk);
        check("R1 idle", {frame_o, pulse_o, done_o}, 0);
        // R4 and R6: each defined code in turn, including accept (0 pulses).
        for (int c = 0; c <= 6; c++) run_report(c, 1'b0);
        // R7: the undefined code is sent as 6 pulses.
        run_report(7, 1'b0);
        // R8: start and code noise during a report.
        run_report(0, 1'b1);
        run_report(6, 1'b1);
        // Seeded random reports.
        void'($urandom(32'h5EED));
        for (int i = 0; i < 40; i++)
            run_report(int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule